// File: doc/BRIEF.md
# Prime-Bank Interleaved Memory Mapper

This block sits in front of a word-addressed store that is split into a prime number of unpipelined banks. Each incoming word address is reduced two ways. The remainder by the bank count picks the bank. The low address bits, which are the remainder by the power-of-two bank depth, pick the word inside that bank. The two moduli share no factor, so each address below their product lands on its own (bank, word) pair. Strided streams then spread across the banks for every stride that is not a multiple of the bank count.

Requests arrive on a valid/ready port. A bank that has taken an access stays busy for a fixed number of cycles. A request to a busy bank sees `req_ready_o` low and must hold its payload stable until ready rises. `req_ready_o` may depend on the address that the request currently presents. Read data leaves on a second valid/ready port, strictly in request order. When the consumer holds `rd_ready_o` low, `rd_data_o` is frozen and the bank that holds the data refuses further work. The banks are modelled as internal arrays. Each accepted access is also shown on a one-hot per-bank command strobe.

Top module: `prime_bank_mapper`

## Requirements
- R1: An accepted in-range request raises exactly one bit of `cmd_vld_o`, bit number (address mod NUM_BANKS), in the handshake cycle; 3 banks by default.
- R2: `cmd_off_o` equals the address mod WORDS_PER_BANK, which is the low log2(WORDS_PER_BANK) address bits; 8 words per bank by default.
- R3: Each address from 0 to NUM_BANKS*WORDS_PER_BANK-1 reaches its own storage word: after a write of a distinct value to every address, a read of each address returns the value written to it.
- R4: After a bank accepts an access, a request to that bank sees `req_ready_o` low for BANK_LAT cycles (4 by default). After a read, the bank also stays unavailable until its data has been taken.
- R5: Read data appears on `rd_valid_o`/`rd_data_o` BANK_LAT cycles after the accepting edge, and reads leave in the order they were accepted, whichever bank holds them.
- R6: A request with an address of NUM_BANKS*WORDS_PER_BANK or above raises `err_o` and is taken at once with `req_ready_o` high. It produces no bank command and no read data.
- R7: A request to an idle bank is accepted in the cycle it is presented, even while other banks are busy.
- R8: While `rd_valid_o` is high and `rd_ready_i` is low, `rd_valid_o` stays high and `rd_data_o` holds its value.
- R9: Reset (`rst_ni` low) clears all busy timers, held read data and pending order entries. After reset, `rd_valid_o` is low and every bank accepts.
- R10: A write produces no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready; low while the addressed bank is occupied |
| req_addr_i | input | ADDR_W | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| err_o | output | 1 | Presented address is out of range |
| cmd_vld_o | output | NUM_BANKS | One-hot per-bank access strobe |
| cmd_off_o | output | log2(WORDS_PER_BANK) | Word offset inside the bank |
| cmd_we_o | output | 1 | Access is a write |
| rd_valid_o | output | 1 | Read data valid |
| rd_ready_i | input | 1 | Read data consumer ready |
| rd_data_o | output | DATA_W | Read data, in request order |

## Verification
Some properties are checked on every cycle. The per-bank strobe is at most one-hot, and no strobe fires with an error. No bank starts while it is busy or holding data. The order queue never overflows or underflows. Read data stays frozen under back-pressure. Other behaviour shows only in the bench scenarios: the actual mapping values, the uniqueness of every address, the exact stall length after writes and reads, the return latency, reordering across banks held by back-pressure, and the clean state after a reset in mid-flight.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  // Remainder of the low nbits of val by modulus, reduced one bit at a
  // time from the top; each stage is a shift, add and one conditional
  // subtract, so the chain unrolls into shallow compare/subtract cells.
  function automatic int unsigned fold_mod(input logic [31:0] val,
                                           input int unsigned nbits,
                                           input int unsigned modulus);
    int unsigned acc;
    acc = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(nbits)) begin
        acc = acc * 2 + 32'(val[i]);
        if (acc >= modulus) acc = acc - modulus;
      end
    end
    return acc;
  endfunction

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pbm_addr_map.sv
module pbm_addr_map #(
  parameter int unsigned NUM_BANKS      = 3,
  parameter int unsigned WORDS_PER_BANK = 8,
  parameter int unsigned ADDR_W         = 5,
  localparam int unsigned BANK_W        = pbm_pkg::width_of(NUM_BANKS),
  localparam int unsigned OFF_W         = pbm_pkg::width_of(WORDS_PER_BANK)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              in_range_o
);
  localparam int unsigned TOTAL_WORDS = NUM_BANKS * WORDS_PER_BANK;

  logic [31:0] addr_ext;

  always_comb begin
    addr_ext   = 32'(addr_i);
    bank_o     = BANK_W'(pbm_pkg::fold_mod(addr_ext, ADDR_W, NUM_BANKS));
    off_o      = addr_ext[OFF_W-1:0];
    in_range_o = (addr_ext < TOTAL_WORDS);
  end
endmodule

// File: rtl/pbm_bank.sv
module pbm_bank #(
  parameter int unsigned WORDS_PER_BANK = 8,
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned BANK_LAT       = 4,
  localparam int unsigned OFF_W         = pbm_pkg::width_of(WORDS_PER_BANK),
  localparam int unsigned LAT_W         = $clog2(BANK_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic              avail_o,
  output logic              hold_vld_o,
  output logic [DATA_W-1:0] hold_data_o
);
  logic [DATA_W-1:0] mem [WORDS_PER_BANK];
  logic [LAT_W-1:0]  busy_q;
  logic              rd_pend_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i) begin
    if (start_i && we_i) mem[off_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q      <= '0;
      rd_pend_q   <= 1'b0;
      data_q      <= '0;
      hold_vld_o  <= 1'b0;
      hold_data_o <= '0;
    end else begin
      if (start_i) begin
        busy_q    <= LAT_W'(BANK_LAT);
        rd_pend_q <= !we_i;
        data_q    <= mem[off_i];
      end else if (busy_q != '0) begin
        busy_q <= busy_q - 1'b1;
        if (busy_q == LAT_W'(1) && rd_pend_q) begin
          hold_vld_o  <= 1'b1;
          hold_data_o <= data_q;
          rd_pend_q   <= 1'b0;
        end
      end
      if (pop_i) hold_vld_o <= 1'b0;
    end
  end

  assign avail_o = (busy_q == '0) && !hold_vld_o;

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> avail_o); // R4
  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_vld_o && !pop_i) |=> (hold_vld_o && $stable(hold_data_o))); // R8
  AST_POP_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> hold_vld_o); // R5
endmodule

// File: rtl/pbm_order_q.sv
module pbm_order_q #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned W     = 2,
  localparam int unsigned PTR_W = pbm_pkg::width_of(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic         full_o,
  output logic [W-1:0] head_o
);
  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) slot[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      if (push_i && !pop_i)      count <= count + 1'b1;
      else if (pop_i && !push_i) count <= count - 1'b1;
    end
  end

  assign empty_o = (count == '0);
  assign full_o  = (count == CNT_W'(DEPTH));
  assign head_o  = slot[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R5
endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper #(
  parameter int unsigned NUM_BANKS      = 3,
  parameter int unsigned WORDS_PER_BANK = 8,
  parameter int unsigned ADDR_W         = 5,
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned BANK_LAT       = 4,
  localparam int unsigned OFF_W         = pbm_pkg::width_of(WORDS_PER_BANK)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 req_we_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 err_o,
  output logic [NUM_BANKS-1:0] cmd_vld_o,
  output logic [OFF_W-1:0]     cmd_off_o,
  output logic                 cmd_we_o,
  output logic                 rd_valid_o,
  input  logic                 rd_ready_i,
  output logic [DATA_W-1:0]    rd_data_o
);
  localparam int unsigned BANK_W = pbm_pkg::width_of(NUM_BANKS);

  logic [BANK_W-1:0]    sel_bank;
  logic [OFF_W-1:0]     sel_off;
  logic                 in_range;
  logic                 sel_avail;
  logic                 accept;
  logic [NUM_BANKS-1:0] bank_avail;
  logic [NUM_BANKS-1:0] hold_vld;
  logic [NUM_BANKS-1:0] bank_pop;
  logic [DATA_W-1:0]    hold_data [NUM_BANKS];
  logic [BANK_W-1:0]    head_bank;
  logic                 q_empty, q_full;
  logic                 head_ready;
  logic                 rd_pop;

  pbm_addr_map #(
    .NUM_BANKS(NUM_BANKS), .WORDS_PER_BANK(WORDS_PER_BANK), .ADDR_W(ADDR_W)
  ) u_map (
    .addr_i(req_addr_i), .bank_o(sel_bank), .off_o(sel_off), .in_range_o(in_range)
  );

  always_comb begin
    sel_avail  = 1'b0;
    head_ready = 1'b0;
    rd_data_o  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_bank == BANK_W'(b)) sel_avail = bank_avail[b];
      if (head_bank == BANK_W'(b)) begin
        head_ready = hold_vld[b];
        rd_data_o  = hold_data[b];
      end
    end
  end

  assign req_ready_o = !in_range || sel_avail;
  assign err_o       = req_valid_i && !in_range;
  assign accept      = req_valid_i && in_range && sel_avail;
  assign cmd_off_o   = sel_off;
  assign cmd_we_o    = req_we_i;
  assign rd_valid_o  = !q_empty && head_ready;
  assign rd_pop      = rd_valid_o && rd_ready_i;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign cmd_vld_o[g] = accept && (sel_bank == BANK_W'(g));
    assign bank_pop[g]  = rd_pop && (head_bank == BANK_W'(g));

    pbm_bank #(
      .WORDS_PER_BANK(WORDS_PER_BANK), .DATA_W(DATA_W), .BANK_LAT(BANK_LAT)
    ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .start_i(cmd_vld_o[g]), .we_i(req_we_i), .off_i(sel_off),
      .wdata_i(req_wdata_i), .pop_i(bank_pop[g]),
      .avail_o(bank_avail[g]), .hold_vld_o(hold_vld[g]),
      .hold_data_o(hold_data[g])
    );
  end

  // At most one read per bank can be outstanding, so NUM_BANKS slots suffice.
  pbm_order_q #(.DEPTH(NUM_BANKS), .W(BANK_W)) u_order (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(accept && !req_we_i), .push_data_i(sel_bank),
    .pop_i(rd_pop), .empty_o(q_empty), .full_o(q_full), .head_o(head_bank)
  );

  AST_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_vld_o)); // R1
  AST_ERR_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cmd_vld_o == '0 && req_ready_o)); // R6
  AST_RD_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o))); // R8
  AST_FULL_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full |-> !(accept && !req_we_i)); // R5
endmodule

// File: tb/test_prime_bank_mapper.sv
`timescale 1ns/1ps
module test_prime_bank_mapper;
  localparam int NB = 3, WPB = 8, AW = 5, DW = 16, LAT = 4;
  localparam int TOTAL = NB * WPB;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_we_i = 1'b0, rd_ready_i = 1'b1;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic req_ready_o, err_o, cmd_we_o, rd_valid_o;
  logic [NB-1:0] cmd_vld_o;
  logic [2:0] cmd_off_o;
  logic [DW-1:0] rd_data_o;

  always #4 clk_i = ~clk_i;

  prime_bank_mapper i_prime_bank_mapper (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_we_i,
    .req_wdata_i, .err_o, .cmd_vld_o, .cmd_off_o, .cmd_we_o,
    .rd_valid_o, .rd_ready_i, .rd_data_o);

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int last_vld, last_off, last_err;

  // {addr[7:0], bank[3:0], off[2:0], err}
  localparam logic [15:0] VEC [9] = '{
    {8'd0,  4'd0, 3'd0, 1'b0}, {8'd1,  4'd1, 3'd1, 1'b0},
    {8'd8,  4'd2, 3'd0, 1'b0}, {8'd9,  4'd0, 3'd1, 1'b0},
    {8'd15, 4'd0, 3'd7, 1'b0}, {8'd16, 4'd1, 3'd0, 1'b0},
    {8'd23, 4'd2, 3'd7, 1'b0}, {8'd24, 4'd0, 3'd0, 1'b1},
    {8'd31, 4'd0, 3'd0, 1'b1}};

  function automatic int val_of(input int a);
    return (a * 37 + 5) & 16'hFFFF;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Present a request at a negedge, wait for ready, capture the command seen.
  task automatic issue(input int addr, input bit we, input int wdata, output int waits);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = AW'(addr); req_we_i = we; req_wdata_i = DW'(wdata);
    waits = 0;
    #1;
    while (!req_ready_o) begin
      waits++;
      @(negedge clk_i); #1;
    end
    last_vld = int'(cmd_vld_o); last_off = int'(cmd_off_o); last_err = int'(err_o);
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic wait_rd(output int n);
    n = 0;
    @(negedge clk_i);
    while (!rd_valid_o) begin n++; @(negedge clk_i); end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w, n;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R9 rd_valid in reset", int'(rd_valid_o), 0);
    check("R9 cmd_vld in reset", int'(cmd_vld_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check("R9 ready after reset", int'(req_ready_o), 1);

    // Mapping table walk (writes of 0; memory is rewritten later)
    for (int i = 0; i < 9; i++) begin
      issue(int'(VEC[i][15:8]), 1'b1, 0, w);
      check("R6 err flag", last_err, int'(VEC[i][0]));
      if (VEC[i][0]) begin
        check("R6 no command on error", last_vld, 0);
        check("R6 taken without wait", w, 0);
      end else begin
        check("R1 bank strobe", last_vld, 1 << int'(VEC[i][7:4]));
        check("R2 offset", last_off, int'(VEC[i][3:1]));
      end
      repeat (LAT + 1) @(negedge clk_i);
    end
    check("R6 R10 no read data", int'(rd_valid_o), 0);

    // R7: consecutive addresses hit different banks, no stall
    issue(0, 1'b1, 0, w);
    issue(1, 1'b1, 0, w);
    check("R7 idle bank accepts at once", w, 0);
    issue(2, 1'b1, 0, w);
    check("R7 idle bank accepts at once", w, 0);
    // R4: same bank right after a write
    issue(3, 1'b1, 0, w);
    check("R4 write busy stall", w, LAT - 2);
    issue(6, 1'b1, 0, w);
    check("R4 write busy stall full", w, LAT);
    repeat (LAT + 1) @(negedge clk_i);
    check("R10 write gives no data", int'(rd_valid_o), 0);

    // R3: write a distinct value everywhere, read each back
    for (int a = 0; a < TOTAL; a++) issue(a, 1'b1, val_of(a), w);
    for (int a = 0; a < TOTAL; a++) begin
      issue(a, 1'b0, 0, w);
      wait_rd(n);
      check("R3 readback", int'(rd_data_o), val_of(a));
      if (a == 5) check("R5 read latency", n, LAT);
    end
    repeat (3) @(negedge clk_i);

    // R4: read then read on the same bank, data taken at once
    issue(4, 1'b0, 0, w);
    issue(7, 1'b0, 0, w);
    check("R4 read busy stall", w, LAT + 1);
    wait_rd(n);
    check("R3 readback", int'(rd_data_o), val_of(7));
    repeat (3) @(negedge clk_i);

    // R5/R8: order kept across banks under back-pressure
    rd_ready_i = 1'b0;
    issue(2, 1'b0, 0, w);
    issue(1, 1'b0, 0, w);
    issue(0, 1'b0, 0, w);
    repeat (LAT + 3) @(negedge clk_i);
    check("R8 valid held", int'(rd_valid_o), 1);
    check("R5 first out", int'(rd_data_o), val_of(2));
    @(negedge clk_i);
    check("R8 data held", int'(rd_data_o), val_of(2));
    req_valid_i = 1'b1; req_addr_i = AW'(5); req_we_i = 1'b0; #1;
    check("R4 held bank refuses", int'(req_ready_o), 0);
    req_valid_i = 1'b0;
    rd_ready_i = 1'b1;
    #1;
    check("R5 order 1", int'(rd_data_o), val_of(2));
    @(negedge clk_i);
    check("R5 order 2", int'(rd_data_o), val_of(1));
    @(negedge clk_i);
    check("R5 order 3", int'(rd_data_o), val_of(0));
    @(negedge clk_i);
    check("R5 drained", int'(rd_valid_o), 0);

    // R9: reset in mid-flight
    issue(4, 1'b0, 0, w);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (LAT + 2) @(negedge clk_i);
    check("R9 no data after reset", int'(rd_valid_o), 0);
    req_valid_i = 1'b1; req_addr_i = AW'(4); #1;
    check("R9 bank idle after reset", int'(req_ready_o), 1);
    req_valid_i = 1'b0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule